// File: doc/BRIEF.md
# Vector Length Control Registers

This block holds the live vector-loop control state for a scalar core: the maximum vector length, the current vector length and the sub-vector (group) length. It also holds the element offsets of an interrupted loop. All of this lives in a single 32-bit packed state word. Lengths are kept in that word minus one, so a 7-bit field covers every length from 1 to 64. Every value that enters the block is clamped to a legal range before it is stored. As a result, the current length never exceeds the maximum length.

Software and the decoder use several paths. Dedicated write ports update each length. A set-length request returns its granted length at once, on the same cycle, so it can be written back to a destination register. A whole-word write restores a complete context. The block also keeps three saved copies of the state word, one each for the user, supervisor and hypervisor levels. A trap-swap pulse exchanges the selected saved copy with the live word on entry to or exit from that level.

Top module: `vl_ctrl_regs`

## Requirements
- R1: After reset, the MVL, VL and SUBVL read ports are all 1. The live word and all three saved words are 0, and the exception output is low.
- R2: A write to the maximum length takes the value 0 as 1 and any value above XLEN (64) as XLEN. The clamped value appears on the read port on the cycle after the write.
- R3: The grant output equals min(max(requested, 1), MVL) in the same cycle as the request. MVL here is the value being written in that cycle, if any. VL holds the granted value from the next cycle on.
- R4: A direct VL write is clamped to the range 1 to MVL.
- R5: A write that lowers MVL below the current VL also lowers VL to the new MVL.
- R6: Layout of the live word: maximum-length field at bits 6:0 and current-length field at bits 13:7, each holding the length minus one. Source offset at bits 20:14, destination offset at bits 27:21, sub-vector field at bits 29:28 (length minus one), and sub-vector offset at bits 31:30.
- R7: A whole-word write limits the maximum-length field to XLEN-1 and the current-length field to the stored maximum-length field. The offsets and the sub-vector field are kept exactly as written.
- R8: A sub-vector length write accepts values 1 to 4.
- R9: A sub-vector write outside 1..4 raises the exception output for exactly the next cycle and leaves the stored sub-vector length unchanged.
- R10: A trap swap with level 0 (user), 1 (supervisor) or 2 (hypervisor) exchanges that saved word with the live word on the next edge. Level 3 has no effect.
- R11: When writes coincide, a trap swap takes precedence over a whole-word write, and a whole-word write takes precedence over the per-register writes. A set-length request takes precedence over a direct VL write.
- R12: A saved-word write applies the same clamping as R7. The saved read port shows the selected saved word combinationally, and shows 0 for selector 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mvl_wr_en | input | 1 | Write maximum length |
| mvl_wr_data | input | LW | Maximum length value |
| vl_wr_en | input | 1 | Write current length |
| vl_wr_data | input | LW | Current length value |
| subvl_wr_en | input | 1 | Write sub-vector length |
| subvl_wr_data | input | 3 | Sub-vector length value |
| state_wr_en | input | 1 | Write whole live word |
| state_wr_data | input | 32 | Live word value |
| setvl_req | input | 1 | Set-length request |
| setvl_len | input | LW | Requested length |
| setvl_grant | output | LW | Granted length |
| trap_swap | input | 1 | Exchange saved and live word |
| trap_level | input | 2 | Level for the swap |
| saved_wr_en | input | 1 | Write a saved word |
| saved_sel | input | 2 | Saved word selector for read and write |
| saved_wr_data | input | 32 | Saved word value |
| saved_rd | output | 32 | Selected saved word |
| mvl_rd | output | LW | Maximum length |
| vl_rd | output | LW | Current length |
| subvl_rd | output | 3 | Sub-vector length |
| state_rd | output | 32 | Live word |
| subvl_exc | output | 1 | Illegal sub-vector value pulse |

## Verification
Two outputs are combinational: the grant and the saved read port. The bench samples them in the same cycle as the stimulus, one time unit after driving the inputs on the falling edge. Every stored value (lengths, live word, saved words) and the exception pulse become visible one edge after the write. The bench therefore drives on a falling edge, lets exactly one rising edge pass, and checks on the next falling edge. The exception is also checked one further cycle later, to confirm that it lasts only one cycle.

// File: rtl/vl_ctrl_regs.sv
module vl_ctrl_regs #(
  parameter int XLEN = 64,
  parameter int LW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mvl_wr_en,
  input  logic [LW-1:0] mvl_wr_data,
  input  logic          vl_wr_en,
  input  logic [LW-1:0] vl_wr_data,
  input  logic          subvl_wr_en,
  input  logic [2:0]    subvl_wr_data,
  input  logic          state_wr_en,
  input  logic [31:0]   state_wr_data,
  input  logic          setvl_req,
  input  logic [LW-1:0] setvl_len,
  output logic [LW-1:0] setvl_grant,
  input  logic          trap_swap,
  input  logic [1:0]    trap_level,
  input  logic          saved_wr_en,
  input  logic [1:0]    saved_sel,
  input  logic [31:0]   saved_wr_data,
  output logic [31:0]   saved_rd,
  output logic [LW-1:0] mvl_rd,
  output logic [LW-1:0] vl_rd,
  output logic [2:0]    subvl_rd,
  output logic [31:0]   state_rd,
  output logic          subvl_exc
);
  localparam logic [6:0]    FMAX = 7'(XLEN - 1);
  localparam logic [LW-1:0] LMAX = LW'(XLEN);
  localparam logic [LW-1:0] ONE  = LW'(1);

  function automatic logic [6:0] len2f(input logic [LW-1:0] l);
    logic [LW-1:0] t;
    if (l == '0)       t = '0;
    else if (l > LMAX) t = LMAX - ONE;
    else               t = l - ONE;
    return t[6:0];
  endfunction

  function automatic logic [LW-1:0] f2len(input logic [6:0] f);
    return LW'(f) + ONE;
  endfunction

  function automatic logic [6:0] fmin(input logic [6:0] a, input logic [6:0] b);
    return (a > b) ? b : a;
  endfunction

  function automatic logic [31:0] sanit(input logic [31:0] w);
    logic [6:0] m;
    m = fmin(w[6:0], FMAX);
    return {w[31:14], fmin(w[13:7], m), m};
  endfunction

  logic [31:0] st_q, st_d, sv_trap;
  logic [31:0] sv_q [3];
  logic        exc_q;
  logic [6:0]  m_eff, g_f, v_new;
  logic [1:0]  sub_f;

  wire trap_ok = trap_swap && (trap_level != 2'd3);
  wire sub_ok  = (subvl_wr_data != 3'd0) && (subvl_wr_data <= 3'd4);

  assign m_eff = mvl_wr_en ? len2f(mvl_wr_data) : st_q[6:0];
  assign g_f   = fmin(len2f(setvl_len), m_eff);
  assign sub_f = 2'(subvl_wr_data - 3'd1);

  always_comb begin
    if (setvl_req)     v_new = g_f;
    else if (vl_wr_en) v_new = fmin(len2f(vl_wr_data), m_eff);
    else               v_new = fmin(st_q[13:7], m_eff);
  end

  always_comb begin
    case (trap_level)
      2'd0:    sv_trap = sv_q[0];
      2'd1:    sv_trap = sv_q[1];
      default: sv_trap = sv_q[2];
    endcase
  end

  always_comb begin
    case (saved_sel)
      2'd0:    saved_rd = sv_q[0];
      2'd1:    saved_rd = sv_q[1];
      2'd2:    saved_rd = sv_q[2];
      default: saved_rd = '0;
    endcase
  end

  always_comb begin
    if (trap_ok)          st_d = sv_trap;
    else if (state_wr_en) st_d = sanit(state_wr_data);
    else st_d = {st_q[31:30], (subvl_wr_en && sub_ok) ? sub_f : st_q[29:28],
                 st_q[27:14], v_new, m_eff};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= '0;
      exc_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      exc_q <= subvl_wr_en && !sub_ok;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (!rst_n)
        sv_q[i] <= '0;
      else if (trap_ok && trap_level == 2'(i))
        sv_q[i] <= st_q;
      else if (saved_wr_en && saved_sel == 2'(i))
        sv_q[i] <= sanit(saved_wr_data);
    end
  end

  assign setvl_grant = f2len(g_f);
  assign mvl_rd      = f2len(st_q[6:0]);
  assign vl_rd       = f2len(st_q[13:7]);
  assign subvl_rd    = {1'b0, st_q[29:28]} + 3'd1;
  assign state_rd    = st_q;
  assign subvl_exc   = exc_q;

  // R2
  mvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mvl_rd >= ONE && mvl_rd <= LMAX);

  // R4
  vl_le_mvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vl_rd >= ONE && vl_rd <= mvl_rd);

  // R3
  setvl_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setvl_req && !trap_ok && !state_wr_en |=> vl_rd == $past(setvl_grant));

  // R10
  swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ok |=> state_rd == $past(sv_trap));

  // R9
  bad_subvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    subvl_wr_en && !sub_ok && !trap_ok && !state_wr_en
    |=> subvl_exc && $stable(subvl_rd));
endmodule

// File: tb/vl_ctrl_regs_tb.sv
module vl_ctrl_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic       mvl_wr_en = 0, vl_wr_en = 0, subvl_wr_en = 0, state_wr_en = 0;
  logic       setvl_req = 0, trap_swap = 0, saved_wr_en = 0;
  logic [7:0] mvl_wr_data = 0, vl_wr_data = 0, setvl_len = 0;
  logic [2:0] subvl_wr_data = 0;
  logic [31:0] state_wr_data = 0, saved_wr_data = 0;
  logic [1:0] trap_level = 0, saved_sel = 0;
  logic [7:0] setvl_grant, mvl_rd, vl_rd;
  logic [2:0] subvl_rd;
  logic [31:0] saved_rd, state_rd;
  logic subvl_exc;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  vl_ctrl_regs dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input int dsv, input int sub, input int dst,
                                       input int src, input int v, input int m);
    return {2'(dsv), 2'(sub), 7'(dst), 7'(src), 7'(v), 7'(m)};
  endfunction

  task automatic idle();
    mvl_wr_en = 0; vl_wr_en = 0; subvl_wr_en = 0; state_wr_en = 0;
    setvl_req = 0; trap_swap = 0; saved_wr_en = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic wr_mvl(input int v);
    mvl_wr_en = 1; mvl_wr_data = 8'(v); tick();
  endtask

  task automatic t_reset();
    check("R1 mvl", 32'(mvl_rd), 1);
    check("R1 vl", 32'(vl_rd), 1);
    check("R1 subvl", 32'(subvl_rd), 1);
    check("R1 state", state_rd, 0);
    check("R1 exc", 32'(subvl_exc), 0);
    for (int i = 0; i < 3; i++) begin
      saved_sel = 2'(i); #1;
      check("R1 saved", saved_rd, 0);
    end
  endtask

  task automatic t_mvl();
    wr_mvl(0);   check("R2 zero", 32'(mvl_rd), 1);
    wr_mvl(200); check("R2 over", 32'(mvl_rd), 64);
    wr_mvl(16);  check("R2 mid", 32'(mvl_rd), 16);
  endtask

  task automatic t_setvl();
    setvl_req = 1; setvl_len = 10; #1;
    check("R3 grant 10", 32'(setvl_grant), 10);
    tick(); check("R3 vl 10", 32'(vl_rd), 10);
    setvl_req = 1; setvl_len = 40; #1;
    check("R3 grant cap", 32'(setvl_grant), 16);
    tick(); check("R3 vl cap", 32'(vl_rd), 16);
    setvl_req = 1; setvl_len = 0; #1;
    check("R3 grant zero", 32'(setvl_grant), 1);
    tick(); check("R6 word", state_rd, pack(0, 0, 0, 0, 0, 15));
    setvl_req = 1; setvl_len = 30; mvl_wr_en = 1; mvl_wr_data = 20; #1;
    check("R3 grant new mvl", 32'(setvl_grant), 20);
    tick(); check("R3 vl new mvl", 32'(vl_rd), 20);
  endtask

  task automatic t_vl();
    wr_mvl(16);
    vl_wr_en = 1; vl_wr_data = 100; tick(); check("R4 trunc", 32'(vl_rd), 16);
    vl_wr_en = 1; vl_wr_data = 0;   tick(); check("R4 zero", 32'(vl_rd), 1);
    vl_wr_en = 1; vl_wr_data = 5;   tick(); check("R4 mid", 32'(vl_rd), 5);
    wr_mvl(3); check("R5 lowered", 32'(vl_rd), 3);
    mvl_wr_en = 1; mvl_wr_data = 8; vl_wr_en = 1; vl_wr_data = 50; tick();
    check("R5 both", 32'(vl_rd), 8);
    vl_wr_en = 1; vl_wr_data = 2; setvl_req = 1; setvl_len = 6; tick();
    check("R11 setvl wins", 32'(vl_rd), 6);
  endtask

  task automatic t_subvl();
    subvl_wr_en = 1; subvl_wr_data = 3; tick();
    check("R8 subvl", 32'(subvl_rd), 3);
    check("R8 field", 32'(state_rd[29:28]), 2);
    check("R9 no exc", 32'(subvl_exc), 0);
    subvl_wr_en = 1; subvl_wr_data = 5; tick();
    check("R9 exc", 32'(subvl_exc), 1);
    check("R9 kept", 32'(subvl_rd), 3);
    @(negedge clk); check("R9 pulse", 32'(subvl_exc), 0);
    subvl_wr_en = 1; subvl_wr_data = 0; tick();
    check("R9 zero exc", 32'(subvl_exc), 1);
    check("R9 zero kept", 32'(subvl_rd), 3);
    subvl_wr_en = 1; subvl_wr_data = 4; tick();
    check("R8 four", 32'(subvl_rd), 4);
  endtask

  task automatic t_state();
    state_wr_en = 1; state_wr_data = pack(2, 1, 9, 5, 120, 100); tick();
    check("R7 clamp", state_rd, pack(2, 1, 9, 5, 63, 63));
    check("R7 mvl", 32'(mvl_rd), 64);
    check("R7 subvl", 32'(subvl_rd), 2);
    state_wr_en = 1; state_wr_data = pack(3, 3, 127, 1, 20, 7); tick();
    check("R7 vl cap", state_rd, pack(3, 3, 127, 1, 7, 7));
    state_wr_en = 1; state_wr_data = pack(0, 0, 0, 0, 1, 4);
    mvl_wr_en = 1; mvl_wr_data = 30; tick();
    check("R11 state over mvl", state_rd, pack(0, 0, 0, 0, 1, 4));
  endtask

  task automatic t_trap();
    logic [31:0] a, b;
    a = pack(1, 2, 3, 4, 5, 6);
    b = pack(0, 1, 10, 11, 12, 40);
    state_wr_en = 1; state_wr_data = a; tick();
    saved_wr_en = 1; saved_sel = 1; saved_wr_data = pack(0, 1, 10, 11, 90, 100); tick();
    saved_sel = 1; #1; check("R12 saved clamp", saved_rd, pack(0, 1, 10, 11, 63, 63));
    saved_wr_en = 1; saved_sel = 1; saved_wr_data = b; tick();
    saved_sel = 3; #1; check("R12 sel3", saved_rd, 0);
    trap_swap = 1; trap_level = 1; tick();
    check("R10 live", state_rd, b);
    saved_sel = 1; #1; check("R10 saved", saved_rd, a);
    trap_swap = 1; trap_level = 3; tick();
    check("R10 lvl3", state_rd, b);
    trap_swap = 1; trap_level = 1; state_wr_en = 1; state_wr_data = 0; tick();
    check("R11 trap wins", state_rd, a);
    saved_sel = 1; #1; check("R10 back", saved_rd, b);
    trap_swap = 1; trap_level = 2; tick();
    check("R10 hyp", state_rd, 0);
    saved_sel = 2; #1; check("R10 hyp saved", saved_rd, a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mvl();
    t_setvl();
    t_vl();
    t_subvl();
    t_state();
    t_trap();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule